// File: doc/BRIEF.md
# Receive Packet Sorter with Per-Channel, Per-Category Buffers

This block sits on the receive side of a packet link, just above the layer that delivers packets whose integrity has already been checked. Each packet arrives as a stream of 32-bit beats. The first beat, marked by a start flag, is a header. Zero or more payload beats follow, and the final beat is marked by an end flag. The block checks that the header is well formed. It then maps the header's traffic class to a virtual channel through a map that software can program. The packet goes into one of three buffer regions owned by that channel, chosen by its category: posted, non-posted or completion. Any packet that is not accepted is dropped whole, and a one-cycle error pulse is raised.

Each region is a circular word buffer with its own small queue. The queue holds the buffer start address of every stored packet. The consumer selects a channel and a category and pulls beats in arrival order. The start flag marks the header and the end flag marks the last beat. The space a packet occupies is returned to the region when its last beat is read. Before accepting a header, the block checks that the target region can hold the whole packet and that its queue has a free slot. If not, it holds back its ready, so a packet is never stored in part.

Top module: `rx_pkt_sorter`

## Requirements
- R1: The header beat carries reserved bits 31, 29 and 23, which must be zero, a has-payload flag in bit 30, a 5-bit type in bits 28:24, a traffic class in bits 22:20 and the payload length in beats in bits 3:0. The header is well formed only if the reserved bits are clear, the type is one of those listed in R2, and the has-payload flag is set exactly when the length is non-zero.
- R2: The category is decoded from the type and the flag. Type 00000 with payload is posted, and type 00000 without payload is non-posted. Types 00010 and 00100 are non-posted. Type 10000 is posted. Type 01010 is completion. Category codes are posted 0, non-posted 1, completion 2. The region index is channel*3 + category.
- R3: The channel of a packet is bit `tc` of `tc_vc_map`. A traffic class whose `tc_enable` bit is clear, or whose mapped channel is not below NUM_VC, has no channel.
- R4: A header that is not well formed, or that has no channel, is accepted and discarded together with all beats up to its end flag. `drop_err` is high for exactly one cycle, the cycle after the header is taken. No queue changes.
- R5: A well-formed packet whose end flag does not arrive on its last declared beat is discarded. This covers an end flag that comes too early and one that is missing on the last beat, in which case the block consumes beats until the end flag. `drop_err` pulses once, the cycle after the offending beat, and no queue changes.
- R6: While a header waits whose target region has fewer free words than length+1, or whose queue is full, `in_ready` is low and nothing is stored.
- R7: For the selected channel and category, `rd_valid` is high while that region's queue is not empty. Beats come out in arrival order, one per cycle with `rd_en` high. `rd_sop` marks the header and `rd_eop` marks the last payload beat. Packets of one region come out in the order they were stored.
- R8: A region's words are freed on the cycle its packet's last beat is read, so a header blocked by R6 is then accepted.
- R9: Each region's address queue holds 8 packets. `q_full` and `q_empty` report its state per region, and a ninth packet for a full queue is held off by R6.
- R10: After reset every queue is empty and not full, `in_ready` is high, `rd_valid` and `drop_err` are low.
- R11: A beat without the start flag arriving between packets is consumed silently, with no error pulse and no change to any queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tc_vc_map | input | 8 | Channel chosen for each traffic class |
| tc_enable | input | 8 | Traffic classes allowed to be stored |
| in_valid | input | 1 | Incoming beat present |
| in_ready | output | 1 | Block takes the beat on this edge |
| in_data | input | DW | Incoming beat |
| in_sop | input | 1 | Beat is a header |
| in_eop | input | 1 | Beat ends the packet |
| drop_err | output | 1 | One-cycle pulse per dropped packet |
| rd_vc | input | 1 | Channel selected for readout |
| rd_cat | input | 2 | Category selected for readout |
| rd_en | input | 1 | Consume the presented beat |
| rd_valid | output | 1 | A beat is presented |
| rd_data | output | DW | Presented beat |
| rd_sop | output | 1 | Presented beat is a header |
| rd_eop | output | 1 | Presented beat is the last of its packet |
| q_empty | output | NUM_VC*3 | Per-region queue empty |
| q_full | output | NUM_VC*3 | Per-region queue full |

## Verification
The hardest situation to reach is a header stalled at the edge while the region space it waits for is freed by the reader. The bench fills one posted region with a single 16-word packet, then holds a one-word header for that region on the input and checks that ready stays low. It drains the large packet through the read port and checks that ready rises in the same cycle the last beat leaves. The same pattern is used on a completion queue filled with eight packets. A second difficult case is a length mismatch found deep inside a packet. The bench drives packets whose end flag comes early, and packets that run past their declared length, and confirms that the following packet is still framed correctly.

// File: rtl/rxs_pkg.sv
package rxs_pkg;

   typedef enum logic [1:0] {
      CAT_POSTED     = 2'd0,
      CAT_NONPOSTED  = 2'd1,
      CAT_COMPLETION = 2'd2,
      CAT_NONE       = 2'd3
   } rxs_cat_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_STORE = 2'd1,
      ST_DROP  = 2'd2
   } rxs_state_e;

   localparam logic [4:0] TY_MEM = 5'b00000;
   localparam logic [4:0] TY_IO  = 5'b00010;
   localparam logic [4:0] TY_CFG = 5'b00100;
   localparam logic [4:0] TY_MSG = 5'b10000;
   localparam logic [4:0] TY_CPL = 5'b01010;

   localparam int CATS_PER_VC = 3;

endpackage

// File: rtl/rxs_hdr_decode.sv
module rxs_hdr_decode
   import rxs_pkg::*;
#(
   parameter int DW     = 32,
   parameter int NUM_VC = 2,
   parameter int LEN_W  = 4
) (
   input  logic [DW-1:0]    hdr,
   input  logic [7:0]       tc_vc_map,
   input  logic [7:0]       tc_enable,
   output logic             hdr_ok,
   output rxs_cat_e         cat,
   output logic             vc,
   output logic [LEN_W-1:0] len
);

   generate
      if (DW < 32) begin : g_bad_dw
         $error("rxs_hdr_decode: DW must be at least 32");
      end
      if (LEN_W < 1 || LEN_W > 16) begin : g_bad_len
         $error("rxs_hdr_decode: LEN_W out of range");
      end
   endgenerate

   logic       has_data;
   logic [4:0] ty;
   logic [2:0] tc;
   logic       rsv_ok;
   logic       len_ok;
   logic       vc_ok;

   assign has_data = hdr[30];
   assign ty       = hdr[28:24];
   assign tc       = hdr[22:20];
   assign len      = hdr[LEN_W-1:0];
   assign rsv_ok   = !hdr[31] && !hdr[29] && !hdr[23];
   assign len_ok   = (has_data == (len != '0));
   assign vc       = tc_vc_map[tc];
   assign vc_ok    = tc_enable[tc] && (int'(vc) < NUM_VC);

   always_comb begin
      case (ty)
         TY_MEM:        cat = has_data ? CAT_POSTED : CAT_NONPOSTED;
         TY_IO, TY_CFG: cat = CAT_NONPOSTED;
         TY_MSG:        cat = CAT_POSTED;
         TY_CPL:        cat = CAT_COMPLETION;
         default:       cat = CAT_NONE;
      endcase
   end

   assign hdr_ok = rsv_ok && len_ok && vc_ok && (cat != CAT_NONE);

endmodule

// File: rtl/rxs_addr_fifo.sv
module rxs_addr_fifo #(
   parameter int W     = 4,
   parameter int DEPTH = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] dout,
   output logic         empty,
   output logic         full
);

   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);

   generate
      if (DEPTH < 2 || (1 << PW) != DEPTH) begin : g_bad_depth
         $error("rxs_addr_fifo: DEPTH must be a power of two of at least 2");
      end
   endgenerate

   logic [W-1:0]  slot [DEPTH];
   logic [PW-1:0] wp;
   logic [PW-1:0] rp;
   logic [CW-1:0] cnt;

   assign empty = (cnt == '0);
   assign full  = (cnt == CW'(DEPTH));
   assign dout  = slot[rp];

   always_ff @(posedge clk) begin
      if (push) slot[wp] <= din;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (push) wp <= wp + 1'b1;
         if (pop)  rp <= rp + 1'b1;
         case ({push, pop})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end

   assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(push && full))
      else $error("address queue pushed while full");

   assert_no_underflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(pop && empty))
      else $error("address queue popped while empty");

endmodule

// File: rtl/rxs_region.sv
module rxs_region #(
   parameter int DW     = 32,
   parameter int DEPTH  = 16,
   parameter int QDEPTH = 8,
   parameter int LEN_W  = 4
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           wr_en,
   input  logic [DW-1:0]  wr_data,
   input  logic           wr_commit,
   input  logic           wr_abort,
   input  logic [LEN_W:0] need,
   output logic           can_accept,
   input  logic           rd_en,
   output logic           rd_valid,
   output logic [DW-1:0]  rd_data,
   output logic           rd_sop,
   output logic           rd_eop,
   output logic           q_empty,
   output logic           q_full
);

   localparam int AW = $clog2(DEPTH);

   generate
      if ((1 << AW) != DEPTH) begin : g_bad_depth
         $error("rxs_region: DEPTH must be a power of two");
      end
      if ((1 << LEN_W) > DEPTH) begin : g_small
         $error("rxs_region: region cannot hold a longest packet");
      end
   endgenerate

   logic [DW-1:0]    mem [DEPTH];
   logic [AW:0]      wptr;
   logic [AW:0]      stage;
   logic [AW:0]      rptr;
   logic [AW:0]      used;
   logic [AW:0]      free_w;
   logic [LEN_W-1:0] beat;
   logic [LEN_W-1:0] pkt_len;
   logic [AW-1:0]    head;
   logic [AW-1:0]    rd_addr;
   logic             push;
   logic             pop;
   logic             rd_fire;

   assign used       = wptr - rptr;
   assign free_w     = (AW+1)'(DEPTH) - used;
   assign can_accept = !q_full && (int'(free_w) >= int'(need));

   // write side: a packet is staged past the committed pointer
   always_ff @(posedge clk) begin
      if (wr_en) mem[stage[AW-1:0]] <= wr_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wptr  <= '0;
         stage <= '0;
      end else if (wr_abort) begin
         stage <= wptr;
      end else if (wr_commit) begin
         stage <= stage + 1'b1;
         wptr  <= stage + 1'b1;
      end else if (wr_en) begin
         stage <= stage + 1'b1;
      end
   end

   assign push = wr_commit && !wr_abort;

   rxs_addr_fifo #(
      .W     (AW),
      .DEPTH (QDEPTH)
   ) i_queue (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (push),
      .din   (wptr[AW-1:0]),
      .pop   (pop),
      .dout  (head),
      .empty (q_empty),
      .full  (q_full)
   );

   // read side: walk the packet at the queue head
   assign pkt_len  = mem[head][LEN_W-1:0];
   assign rd_addr  = head + AW'(beat);
   assign rd_valid = !q_empty;
   assign rd_data  = mem[rd_addr];
   assign rd_sop   = (beat == '0);
   assign rd_eop   = (beat == pkt_len);
   assign rd_fire  = rd_en && rd_valid;
   assign pop      = rd_fire && rd_eop;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         beat <= '0;
         rptr <= '0;
      end else if (pop) begin
         beat <= '0;
         rptr <= rptr + (AW+1)'(pkt_len) + 1'b1;
      end else if (rd_fire) begin
         beat <= beat + 1'b1;
      end
   end

   assert_commit_with_beat_R4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_commit |-> wr_en)
      else $error("commit without a written beat");

   assert_commit_abort_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_commit && wr_abort))
      else $error("commit and abort together");

   assert_space_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
      int'(used) <= DEPTH)
      else $error("region holds more words than it has");

   assert_head_matches_rptr_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !q_empty |-> (rptr[AW-1:0] == head))
      else $error("queue head and read pointer disagree");

   assert_beat_in_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !q_empty |-> (beat <= pkt_len))
      else $error("read beat past packet end");

endmodule

// File: rtl/rx_pkt_sorter.sv
module rx_pkt_sorter
   import rxs_pkg::*;
#(
   parameter int DW           = 32,
   parameter int NUM_VC       = 2,
   parameter int REGION_DEPTH = 16,
   parameter int QUEUE_DEPTH  = 8,
   parameter int LEN_W        = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [7:0]            tc_vc_map,
   input  logic [7:0]            tc_enable,
   input  logic                  in_valid,
   output logic                  in_ready,
   input  logic [DW-1:0]         in_data,
   input  logic                  in_sop,
   input  logic                  in_eop,
   output logic                  drop_err,
   input  logic                  rd_vc,
   input  logic [1:0]            rd_cat,
   input  logic                  rd_en,
   output logic                  rd_valid,
   output logic [DW-1:0]         rd_data,
   output logic                  rd_sop,
   output logic                  rd_eop,
   output logic [NUM_VC*3-1:0]   q_empty,
   output logic [NUM_VC*3-1:0]   q_full
);

   localparam int NREG  = NUM_VC * CATS_PER_VC;
   localparam int REG_W = $clog2(NREG);

   generate
      if (NUM_VC < 1 || NUM_VC > 2) begin : g_bad_vc
         $error("rx_pkt_sorter: NUM_VC must be 1 or 2");
      end
   endgenerate

   logic             dec_ok;
   rxs_cat_e         dec_cat;
   logic             dec_vc;
   logic [LEN_W-1:0] dec_len;
   logic [REG_W-1:0] tgt;

   rxs_hdr_decode #(
      .DW     (DW),
      .NUM_VC (NUM_VC),
      .LEN_W  (LEN_W)
   ) i_decode (
      .hdr       (in_data),
      .tc_vc_map (tc_vc_map),
      .tc_enable (tc_enable),
      .hdr_ok    (dec_ok),
      .cat       (dec_cat),
      .vc        (dec_vc),
      .len       (dec_len)
   );

   assign tgt = REG_W'(int'(dec_vc) * CATS_PER_VC + int'(dec_cat));

   rxs_state_e       state, state_nxt;
   logic [REG_W-1:0] cur_reg, cur_reg_nxt;
   logic [LEN_W-1:0] remain, remain_nxt;
   logic             err_now;
   logic [NREG-1:0]  wr_en_v;
   logic [NREG-1:0]  commit_v;
   logic [NREG-1:0]  abort_v;
   logic [NREG-1:0]  can_acc_v;
   logic             accept;

   assign accept = in_valid && in_ready;

   always_comb begin
      state_nxt   = state;
      cur_reg_nxt = cur_reg;
      remain_nxt  = remain;
      err_now     = 1'b0;
      wr_en_v     = '0;
      commit_v    = '0;
      abort_v     = '0;
      in_ready    = 1'b1;
      case (state)
         ST_IDLE: begin
            if (in_valid && in_sop) begin
               if (!dec_ok) begin
                  if (accept) begin
                     err_now = 1'b1;
                     if (!in_eop) state_nxt = ST_DROP;
                  end
               end else begin
                  in_ready = can_acc_v[tgt];
                  if (accept) begin
                     wr_en_v[tgt] = 1'b1;
                     if (dec_len == '0) begin
                        if (in_eop) begin
                           commit_v[tgt] = 1'b1;
                        end else begin
                           abort_v[tgt] = 1'b1;
                           err_now      = 1'b1;
                           state_nxt    = ST_DROP;
                        end
                     end else if (in_eop) begin
                        abort_v[tgt] = 1'b1;
                        err_now      = 1'b1;
                     end else begin
                        state_nxt   = ST_STORE;
                        remain_nxt  = dec_len;
                        cur_reg_nxt = tgt;
                     end
                  end
               end
            end
         end
         ST_STORE: begin
            if (in_valid) begin
               wr_en_v[cur_reg] = 1'b1;
               if (remain == LEN_W'(1)) begin
                  if (in_eop) begin
                     commit_v[cur_reg] = 1'b1;
                     state_nxt         = ST_IDLE;
                  end else begin
                     abort_v[cur_reg] = 1'b1;
                     err_now          = 1'b1;
                     state_nxt        = ST_DROP;
                  end
               end else if (in_eop) begin
                  abort_v[cur_reg] = 1'b1;
                  err_now          = 1'b1;
                  state_nxt        = ST_IDLE;
               end else begin
                  remain_nxt = remain - 1'b1;
               end
            end
         end
         ST_DROP: begin
            if (in_valid && in_eop) state_nxt = ST_IDLE;
         end
         default: state_nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         cur_reg  <= '0;
         remain   <= '0;
         drop_err <= 1'b0;
      end else begin
         state    <= state_nxt;
         cur_reg  <= cur_reg_nxt;
         remain   <= remain_nxt;
         drop_err <= err_now;
      end
   end

   // read selection
   int               rd_sel;
   logic             sel_ok;
   logic [NREG-1:0]  rv_v, rs_v, re_v;
   logic [DW-1:0]    rdata_a [NREG];
   logic [REG_W-1:0] rd_idx;

   assign rd_sel = int'(rd_vc) * CATS_PER_VC + int'(rd_cat);
   assign sel_ok = (rd_cat != 2'd3) && (rd_sel < NREG);
   assign rd_idx = REG_W'(rd_sel);

   generate
      for (genvar g = 0; g < NREG; g++) begin : g_region
         rxs_region #(
            .DW     (DW),
            .DEPTH  (REGION_DEPTH),
            .QDEPTH (QUEUE_DEPTH),
            .LEN_W  (LEN_W)
         ) i_region (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_en      (wr_en_v[g]),
            .wr_data    (in_data),
            .wr_commit  (commit_v[g]),
            .wr_abort   (abort_v[g]),
            .need       ({1'b0, dec_len} + 1'b1),
            .can_accept (can_acc_v[g]),
            .rd_en      (rd_en && sel_ok && (rd_sel == g)),
            .rd_valid   (rv_v[g]),
            .rd_data    (rdata_a[g]),
            .rd_sop     (rs_v[g]),
            .rd_eop     (re_v[g]),
            .q_empty    (q_empty[g]),
            .q_full     (q_full[g])
         );
      end
   endgenerate

   assign rd_valid = sel_ok && rv_v[rd_idx];
   assign rd_data  = sel_ok ? rdata_a[rd_idx] : '0;
   assign rd_sop   = sel_ok && rs_v[rd_idx];
   assign rd_eop   = sel_ok && re_v[rd_idx];

   assert_err_after_beat_R4: assert property (@(posedge clk) disable iff (!rst_n)
      drop_err |-> $past(in_valid && in_ready))
      else $error("error pulse without an accepted beat");

   assert_one_region_written_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(wr_en_v))
      else $error("beat written to several regions");

endmodule

// File: tb/test_rx_pkt_sorter.sv
`timescale 1ns/1ps
module test_rx_pkt_sorter;
   import rxs_pkg::*;

   localparam int NREG = 6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  tc_vc_map = 8'hF0;
   logic [7:0]  tc_enable = 8'h7F;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [31:0] in_data = '0;
   logic        in_sop = 1'b0;
   logic        in_eop = 1'b0;
   logic        drop_err;
   logic        rd_vc = 1'b0;
   logic [1:0]  rd_cat = 2'd0;
   logic        rd_en = 1'b0;
   logic        rd_valid;
   logic [31:0] rd_data;
   logic        rd_sop;
   logic        rd_eop;
   logic [NREG-1:0] q_empty;
   logic [NREG-1:0] q_full;

   always #4 clk = ~clk;

   rx_pkt_sorter i_rx_pkt_sorter (
      .clk(clk), .rst_n(rst_n), .tc_vc_map(tc_vc_map), .tc_enable(tc_enable),
      .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
      .in_sop(in_sop), .in_eop(in_eop), .drop_err(drop_err),
      .rd_vc(rd_vc), .rd_cat(rd_cat), .rd_en(rd_en), .rd_valid(rd_valid),
      .rd_data(rd_data), .rd_sop(rd_sop), .rd_eop(rd_eop),
      .q_empty(q_empty), .q_full(q_full)
   );

   int n_chk = 0;
   int n_fail = 0;
   int err_cnt = 0;

   always @(posedge clk) if (rst_n && drop_err) err_cnt++;

   function automatic logic [31:0] mk(input logic hd, input logic [4:0] ty,
                                      input logic [2:0] tc, input logic [3:0] ln,
                                      input logic rsv);
      return {rsv, hd, 1'b0, ty, 1'b0, tc, 16'h0000, ln};
   endfunction

   function automatic logic [31:0] pay(input logic [31:0] h, input int i);
      return ~h + 32'(i * 32'h0101_0013);
   endfunction

   // vector table: header and expected region (-1 = dropped)
   localparam int NV = 12;
   localparam logic [31:0] V_HDR [NV] = '{
      mk(1'b1, TY_MEM, 3'd0, 4'd2, 1'b0),
      mk(1'b0, TY_MEM, 3'd1, 4'd0, 1'b0),
      mk(1'b1, TY_CPL, 3'd5, 4'd3, 1'b0),
      mk(1'b0, TY_MSG, 3'd4, 4'd0, 1'b0),
      mk(1'b1, TY_CFG, 3'd2, 4'd1, 1'b0),
      mk(1'b0, TY_IO,  3'd6, 4'd0, 1'b0),
      mk(1'b0, TY_CPL, 3'd0, 4'd0, 1'b0),
      mk(1'b1, TY_MEM, 3'd7, 4'd1, 1'b0),
      mk(1'b0, 5'b00110, 3'd0, 4'd0, 1'b0),
      mk(1'b1, TY_MEM, 3'd0, 4'd0, 1'b0),
      mk(1'b0, TY_MEM, 3'd0, 4'd2, 1'b0),
      mk(1'b1, TY_MEM, 3'd0, 4'd1, 1'b1)
   };
   localparam int V_REG [NV] = '{0, 1, 5, 3, 1, 4, 2, -1, -1, -1, -1, -1};

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic beat(input logic [31:0] d, input logic s, input logic e);
      @(negedge clk);
      in_valid = 1'b1; in_data = d; in_sop = s; in_eop = e;
      #1;
      while (!in_ready) begin
         @(negedge clk); #1;
      end
      @(posedge clk);
   endtask

   task automatic idle_in();
      @(negedge clk);
      in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
   endtask

   task automatic send_pkt(input logic [31:0] h, input int npay);
      beat(h, 1'b1, npay == 0);
      for (int i = 1; i <= npay; i++) beat(pay(h, i), 1'b0, i == npay);
      idle_in();
   endtask

   task automatic read_pkt(input int reg_i, input logic [31:0] h, input string req);
      int ln;
      ln = int'(h[3:0]);
      @(negedge clk);
      rd_vc = 1'(reg_i / 3); rd_cat = 2'(reg_i % 3); rd_en = 1'b0;
      #1;
      for (int n = 0; n <= ln; n++) begin
         chk(req, "rd_valid", 32'(rd_valid), 32'd1);
         chk(req, "rd_data", rd_data, (n == 0) ? h : pay(h, n));
         chk(req, "rd_sop", 32'(rd_sop), 32'(n == 0));
         chk(req, "rd_eop", 32'(rd_eop), 32'(n == ln));
         rd_en = 1'b1;
         @(posedge clk);
         @(negedge clk);
         rd_en = 1'b0;
         #1;
      end
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [31:0] h_big, h_msg, h_cpl, h_a, h_b, h_ok;
      int e0;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk); #1;
      // R10 reset state
      chk("R10", "q_empty", 32'(q_empty), 32'h3F);
      chk("R10", "q_full", 32'(q_full), 32'h0);
      chk("R10", "in_ready", 32'(in_ready), 32'd1);
      chk("R10", "rd_valid", 32'(rd_valid), 32'd0);
      chk("R10", "drop_err", 32'(drop_err), 32'd0);

      // vector table: R1 R2 R3 R4
      for (int v = 0; v < NV; v++) begin
         e0 = err_cnt;
         send_pkt(V_HDR[v], int'(V_HDR[v][3:0]));
         repeat (2) @(negedge clk);
         #1;
         chk("R1 R4", $sformatf("vec%0d err pulses", v), 32'(err_cnt - e0),
             (V_REG[v] < 0) ? 32'd1 : 32'd0);
         if (V_REG[v] >= 0) begin
            chk("R2 R3", $sformatf("vec%0d region filled", v),
                32'(q_empty), 32'h3F & ~(32'd1 << V_REG[v]));
            read_pkt(V_REG[v], V_HDR[v], "R2 R3 R7");
         end
         chk("R4", $sformatf("vec%0d queues empty", v), 32'(q_empty), 32'h3F);
      end

      // R7 ordering within one region
      h_a = mk(1'b1, TY_MEM, 3'd1, 4'd1, 1'b0);
      h_b = mk(1'b1, TY_MEM, 3'd2, 4'd2, 1'b0);
      send_pkt(h_a, 1);
      send_pkt(h_b, 2);
      read_pkt(0, h_a, "R7 first");
      read_pkt(0, h_b, "R7 second");
      chk("R7", "posted empty", 32'(q_empty[0]), 32'd1);

      // R5 early end flag
      e0 = err_cnt;
      h_ok = mk(1'b1, TY_MEM, 3'd0, 4'd2, 1'b0);
      beat(h_ok, 1'b1, 1'b0);
      beat(pay(h_ok, 1), 1'b0, 1'b1);
      idle_in();
      repeat (2) @(negedge clk); #1;
      chk("R5", "short err", 32'(err_cnt - e0), 32'd1);
      chk("R5", "short nothing stored", 32'(q_empty), 32'h3F);

      // R5 missing end flag
      e0 = err_cnt;
      h_ok = mk(1'b1, TY_MEM, 3'd0, 4'd1, 1'b0);
      beat(h_ok, 1'b1, 1'b0);
      beat(pay(h_ok, 1), 1'b0, 1'b0);
      beat(pay(h_ok, 2), 1'b0, 1'b0);
      beat(pay(h_ok, 3), 1'b0, 1'b1);
      idle_in();
      repeat (2) @(negedge clk); #1;
      chk("R5", "long err", 32'(err_cnt - e0), 32'd1);
      chk("R5", "long nothing stored", 32'(q_empty), 32'h3F);
      h_ok = mk(1'b1, TY_CPL, 3'd5, 4'd1, 1'b0);
      send_pkt(h_ok, 1);
      read_pkt(5, h_ok, "R5 framing after drop");

      // R11 stray beat between packets
      e0 = err_cnt;
      beat(32'h1234_5678, 1'b0, 1'b1);
      idle_in();
      repeat (2) @(negedge clk); #1;
      chk("R11", "stray err", 32'(err_cnt - e0), 32'd0);
      chk("R11", "stray queues", 32'(q_empty), 32'h3F);

      // R6 R8 region space back-pressure
      h_big = mk(1'b1, TY_MEM, 3'd0, 4'd15, 1'b0);
      h_msg = mk(1'b0, TY_MSG, 3'd0, 4'd0, 1'b0);
      send_pkt(h_big, 15);
      @(negedge clk);
      in_valid = 1'b1; in_data = h_msg; in_sop = 1'b1; in_eop = 1'b1;
      #1;
      chk("R6", "ready low on full region", 32'(in_ready), 32'd0);
      repeat (3) @(negedge clk);
      #1;
      chk("R6", "ready still low", 32'(in_ready), 32'd0);
      read_pkt(0, h_big, "R6 big packet");
      chk("R8", "ready after free", 32'(in_ready), 32'd1);
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
      read_pkt(0, h_msg, "R8 held header stored");
      chk("R8", "posted empty", 32'(q_empty[0]), 32'd1);

      // R9 queue depth
      h_cpl = mk(1'b0, TY_CPL, 3'd0, 4'd0, 1'b0);
      for (int k = 0; k < 8; k++) send_pkt(h_cpl, 0);
      @(negedge clk); #1;
      chk("R9", "queue full", 32'(q_full[2]), 32'd1);
      in_valid = 1'b1; in_data = h_cpl; in_sop = 1'b1; in_eop = 1'b1;
      #1;
      chk("R9", "ninth held off", 32'(in_ready), 32'd0);
      @(negedge clk);
      in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
      read_pkt(2, h_cpl, "R9 drain one");
      chk("R9", "not full after read", 32'(q_full[2]), 32'd0);
      send_pkt(h_cpl, 0);
      for (int k = 0; k < 8; k++) read_pkt(2, h_cpl, "R9 drain");
      chk("R9", "queue empty", 32'(q_empty[2]), 32'd1);
      chk("R9", "rd_valid low", 32'(rd_valid), 32'd0);

      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

endmodule